// File: doc/BRIEF.md
# Bank-Partitioned Search CAM

This block is a binary content-addressable memory whose entries are split evenly across four banks. The two most significant bits of every word act as a bank address. On a write they pick the bank that receives the word. On a search they pick the only bank whose entries are compared. The other banks keep their comparators gated off. Each entry stores only the bits below the bank field, together with a valid bit.

A write places the word in the lowest-numbered free slot of its bank. A write aimed at a full bank is dropped and reported with a one-cycle pulse, even when other banks still have room. Entries are freed by a delete port that takes a global entry address. A search returns a hit flag, a miss flag and the global address of the matching entry one clock after it is presented. If several entries match, the lowest local index wins. A per-bank full vector shows how occupied the banks are.

Top module: `bank_cam`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, no entry is valid and every output is zero (`result_valid`, `result_hit`, `result_miss`, `result_addr`, `wr_overflow`, `bank_full`).
- R2: The bank of a word is its top two bits (`word[15:14]` at default width). An entry keeps only the low 14 bits, and a search compares those bits within the chosen bank.
- R3: A search only compares entries of the bank named by its own top bits. A stored word with equal low bits in another bank never hits.
- R4: An accepted write sets the lowest-indexed invalid slot of its bank valid. The new entry is visible to searches from the next cycle.
- R5: `result_valid` is high exactly one cycle after `sr_valid`. The search sees the contents as they were in its own cycle, so a write in that same cycle is not seen.
- R6: On a hit, `result_addr` is `{bank, local_index}` (bank in bits [3:2], local index in bits [1:0] at default size).
- R7: When several valid entries of the bank match, the lowest local index is reported.
- R8: A search that finds no valid matching entry gives `result_miss`=1, `result_hit`=0 and `result_addr`=0. Without a search, hit and miss are both 0.
- R9: A write to a bank whose entries are all valid changes no entry. It raises `wr_overflow` for exactly the one following cycle.
- R10: `bank_full[b]` is high exactly when every entry of bank b is valid.
- R11: `del_valid` clears the entry at global address `del_addr` from the next cycle. A write in the same cycle chooses its slot from the occupancy before the delete, so a write to a full bank still overflows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Insert `wr_word` into its bank |
| wr_word | input | 16 | Word to insert; top bits select the bank |
| del_valid | input | 1 | Invalidate the entry at `del_addr` |
| del_addr | input | 4 | Global entry address {bank, local index} |
| sr_valid | input | 1 | Start a search for `sr_word` |
| sr_word | input | 16 | Search word; top bits select the bank |
| result_valid | output | 1 | A search result is present |
| result_hit | output | 1 | The search matched a valid entry |
| result_miss | output | 1 | The search matched nothing |
| result_addr | output | 4 | Global address of the winning entry, zero otherwise |
| wr_overflow | output | 1 | One-cycle pulse: the previous write hit a full bank |
| bank_full | output | 4 | Per-bank all-entries-valid flags |

## Verification
The hardest state to reach from the ports is a full bank meeting a write while a delete targets the same bank in the same cycle. This case separates the design that uses pre-delete occupancy from one that reuses the freed slot. The directed phase fills one bank with duplicate words and forces overflow with and without a simultaneous delete. A random phase then draws search and write words from a four-value low-bit alphabet across all banks. That keeps banks near full and gives many multi-entry matches, which a behavioural model checks every cycle.

// File: rtl/cam_pkg.sv
package cam_pkg;

  localparam int unsigned DEF_WORD_W    = 16;
  localparam int unsigned DEF_BANK_BITS = 2;
  localparam int unsigned DEF_DEPTH     = 4;

  // global entry number from bank number and slot inside the bank
  function automatic int addr_join(input int bank, input int idx, input int idx_w);
    return bank * (1 << idx_w) + idx;
  endfunction

endpackage

// File: rtl/cam_prio_enc.sv
module cam_prio_enc #(
  parameter int unsigned N = 4,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);

  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end

endmodule

// File: rtl/cam_bank.sv
module cam_bank #(
  parameter int unsigned LOCAL_W = 14,
  parameter int unsigned DEPTH   = 4,
  localparam int unsigned IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [LOCAL_W-1:0] wr_data,
  input  logic               del_en,
  input  logic [IDX_W-1:0]   del_idx,
  input  logic               srch_en,
  input  logic [LOCAL_W-1:0] key,
  output logic               full,
  output logic               hit,
  output logic [IDX_W-1:0]   hit_idx
);

  logic [DEPTH-1:0]   valid_q;
  logic [LOCAL_W-1:0] data_q [DEPTH];
  logic [DEPTH-1:0]   match_vec;
  logic [DEPTH-1:0]   free_vec;
  logic               free_any;
  logic [IDX_W-1:0]   free_idx;
  logic               do_write;

  function automatic logic [DEPTH-1:0] below(input logic [IDX_W-1:0] k);
    logic [DEPTH-1:0] m;
    m = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (i < int'(k)) m[i] = 1'b1;
    end
    return m;
  endfunction

  // per-entry comparators, enabled only when this bank is searched
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign match_vec[g] = srch_en && valid_q[g] && (data_q[g] == key);
  end

  assign free_vec = ~valid_q;
  assign full     = &valid_q;
  assign do_write = wr_en && free_any;

  cam_prio_enc #(.N(DEPTH)) i_match_enc (.req(match_vec), .any(hit), .idx(hit_idx));
  cam_prio_enc #(.N(DEPTH)) i_free_enc  (.req(free_vec), .any(free_any), .idx(free_idx));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else begin
      if (del_en)   valid_q[del_idx]  <= 1'b0;
      if (do_write) valid_q[free_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_write) data_q[free_idx] <= wr_data;
  end

  // R9
  drop_on_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full && !del_en) |=> $stable(valid_q));

  // R4
  alloc_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !full && !del_en) |=> ($countones(valid_q) == $countones($past(valid_q)) + 1));

  // R7
  lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (match_vec[hit_idx] && ((match_vec & below(hit_idx)) == '0)));

endmodule

// File: rtl/bank_cam.sv
module bank_cam #(
  parameter int unsigned WORD_W    = cam_pkg::DEF_WORD_W,
  parameter int unsigned BANK_BITS = cam_pkg::DEF_BANK_BITS,
  parameter int unsigned DEPTH     = cam_pkg::DEF_DEPTH,
  localparam int unsigned NUM_BANKS = 1 << BANK_BITS,
  localparam int unsigned LOCAL_W   = WORD_W - BANK_BITS,
  localparam int unsigned IDX_W     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned ADDR_W    = BANK_BITS + IDX_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_valid,
  input  logic [WORD_W-1:0]    wr_word,
  input  logic                 del_valid,
  input  logic [ADDR_W-1:0]    del_addr,
  input  logic                 sr_valid,
  input  logic [WORD_W-1:0]    sr_word,
  output logic                 result_valid,
  output logic                 result_hit,
  output logic                 result_miss,
  output logic [ADDR_W-1:0]    result_addr,
  output logic                 wr_overflow,
  output logic [NUM_BANKS-1:0] bank_full
);

  logic [BANK_BITS-1:0] wr_bank, sr_bank, del_bank;
  logic [IDX_W-1:0]     del_idx;
  logic [NUM_BANKS-1:0] bank_hit;
  logic [IDX_W-1:0]     bank_hit_idx [NUM_BANKS];
  logic                 sel_hit;
  logic [IDX_W-1:0]     sel_idx;
  logic                 wr_blocked;

  assign wr_bank  = wr_word[WORD_W-1 -: BANK_BITS];
  assign sr_bank  = sr_word[WORD_W-1 -: BANK_BITS];
  assign del_bank = del_addr[ADDR_W-1 -: BANK_BITS];
  assign del_idx  = del_addr[IDX_W-1:0];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    cam_bank #(.LOCAL_W(LOCAL_W), .DEPTH(DEPTH)) i_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_valid && (wr_bank == BANK_BITS'(b))),
      .wr_data (wr_word[LOCAL_W-1:0]),
      .del_en  (del_valid && (del_bank == BANK_BITS'(b))),
      .del_idx (del_idx),
      .srch_en (sr_valid && (sr_bank == BANK_BITS'(b))),
      .key     (sr_word[LOCAL_W-1:0]),
      .full    (bank_full[b]),
      .hit     (bank_hit[b]),
      .hit_idx (bank_hit_idx[b])
    );
  end

  assign sel_hit    = |bank_hit;
  assign sel_idx    = bank_hit_idx[sr_bank];
  assign wr_blocked = wr_valid && bank_full[wr_bank];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_valid <= 1'b0;
      result_hit   <= 1'b0;
      result_miss  <= 1'b0;
      result_addr  <= '0;
      wr_overflow  <= 1'b0;
    end else begin
      result_valid <= sr_valid;
      result_hit   <= sel_hit;
      result_miss  <= sr_valid && !sel_hit;
      result_addr  <= sel_hit
                      ? ADDR_W'(cam_pkg::addr_join(int'(sr_bank), int'(sel_idx), IDX_W))
                      : '0;
      wr_overflow  <= wr_blocked;
    end
  end

  // R3
  one_bank_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_hit));

  // R6
  addr_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    result_hit |-> (result_addr[ADDR_W-1 -: BANK_BITS] == $past(sr_bank)));

  // R8
  miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    result_miss |-> (result_valid && !result_hit && result_addr == '0));

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_overflow |-> $past(|bank_full));

endmodule

// File: tb/test_bank_cam.sv
`timescale 1ns/1ps
module test_bank_cam;

  localparam int WW = 16;
  localparam int LW = 14;
  localparam int DP = 4;
  localparam int NB = 4;
  localparam int NE = NB * DP;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0, del_valid = 1'b0, sr_valid = 1'b0;
  logic [WW-1:0] wr_word = '0, sr_word = '0;
  logic [3:0] del_addr = '0;
  logic result_valid, result_hit, result_miss, wr_overflow;
  logic [3:0] result_addr;
  logic [NB-1:0] bank_full;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  bank_cam i_bank_cam (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_word(wr_word),
    .del_valid(del_valid), .del_addr(del_addr),
    .sr_valid(sr_valid), .sr_word(sr_word),
    .result_valid(result_valid), .result_hit(result_hit), .result_miss(result_miss),
    .result_addr(result_addr), .wr_overflow(wr_overflow), .bank_full(bank_full)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  // ---------------- behavioural reference ----------------
  int m_valid [NE];
  int m_data  [NE];
  int e_rv, e_hit, e_miss, e_addr, e_ovf;

  always @(posedge clk) begin
    int b, slot;
    if (!rst_n) begin
      for (int i = 0; i < NE; i++) m_valid[i] = 0;
      e_rv = 0; e_hit = 0; e_miss = 0; e_addr = 0; e_ovf = 0;
    end else begin
      e_rv = sr_valid; e_hit = 0; e_miss = 0; e_addr = 0;
      if (sr_valid) begin
        b = int'(sr_word) / (1 << LW);
        for (int i = DP - 1; i >= 0; i--)
          if (m_valid[b*DP+i] != 0 && m_data[b*DP+i] == int'(sr_word) % (1 << LW)) begin
            e_hit = 1; e_addr = b*DP+i;
          end
        e_miss = (e_hit == 0) ? 1 : 0;
      end
      e_ovf = 0; slot = -1;
      if (wr_valid) begin
        b = int'(wr_word) / (1 << LW);
        for (int i = DP - 1; i >= 0; i--)
          if (m_valid[b*DP+i] == 0) slot = b*DP+i;
        if (slot < 0) e_ovf = 1;
      end
      if (del_valid) m_valid[del_addr] = 0;
      if (slot >= 0) begin
        m_valid[slot] = 1;
        m_data[slot]  = int'(wr_word) % (1 << LW);
      end
    end
  end

  always @(negedge clk) begin
    int full_exp;
    if (rst_n) begin
      full_exp = 0;
      for (int b = 0; b < NB; b++) begin
        int cnt;
        cnt = 0;
        for (int i = 0; i < DP; i++) cnt += m_valid[b*DP+i];
        if (cnt == DP) full_exp += (1 << b);
      end
      chk("R5 result_valid", result_valid, e_rv);
      chk("R3 result_hit",   result_hit,   e_hit);
      chk("R8 result_miss",  result_miss,  e_miss);
      chk("R6 result_addr",  result_addr,  e_addr);
      chk("R9 wr_overflow",  wr_overflow,  e_ovf);
      chk("R10 bank_full",   bank_full,    full_exp);
    end
  end

  // ---------------- stimulus ----------------
  task automatic ops(input bit w, input logic [WW-1:0] ww, input bit d,
                     input logic [3:0] da, input bit s, input logic [WW-1:0] sw);
    @(negedge clk);
    wr_valid = w; wr_word = ww; del_valid = d; del_addr = da; sr_valid = s; sr_word = sw;
    @(negedge clk);
    wr_valid = 0; del_valid = 0; sr_valid = 0;
  endtask

  task automatic wr(input logic [WW-1:0] w); ops(1, w, 0, 0, 0, 0); endtask
  task automatic sr(input logic [WW-1:0] w); ops(0, 0, 0, 0, 1, w); endtask

  initial begin
    #(200000 * 10);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs zero during reset
    chk("R1 reset outputs", {result_valid, result_hit, result_miss, result_addr, wr_overflow, bank_full}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {result_valid, result_hit, result_miss, result_addr, wr_overflow, bank_full}, 0);

    wr(16'h4005);
    sr(16'h4005);
    chk("R2 bank1 first entry addr", result_addr, 4);
    chk("R4 first slot hit", result_hit, 1);
    wr(16'h4009);
    sr(16'h4009);
    chk("R4 second slot addr", result_addr, 5);
    sr(16'h0005);
    chk("R3 other bank same low bits", result_miss, 1);
    wr(16'h4005);
    sr(16'h4005);
    chk("R7 duplicate lowest index", result_addr, 4);
    ops(0, 0, 1, 4'd4, 0, 0);
    sr(16'h4005);
    chk("R11 after delete next duplicate", result_addr, 6);
    wr(16'h4111);
    sr(16'h4111);
    chk("R4 reuse freed lowest slot", result_addr, 4);
    wr(16'h4222);
    chk("R10 bank1 full", bank_full, 4'b0010);
    wr(16'h4333);
    chk("R9 overflow pulse", wr_overflow, 1);
    @(negedge clk);
    chk("R9 overflow single cycle", wr_overflow, 0);
    sr(16'h4333);
    chk("R9 dropped word misses", result_miss, 1);
    ops(1, 16'h4444, 1, 4'd5, 0, 0);
    chk("R11 write with delete on full bank", wr_overflow, 1);
    chk("R10 bank1 no longer full", bank_full, 4'b0000);
    sr(16'h4444);
    chk("R11 dropped write misses", result_miss, 1);
    wr(16'h4444);
    sr(16'h4444);
    chk("R11 freed slot used later", result_addr, 5);
    ops(1, 16'h8777, 0, 0, 1, 16'h8777);
    chk("R5 same-cycle write unseen", result_miss, 1);
    chk("R5 result_valid one cycle later", result_valid, 1);
    sr(16'h8777);
    chk("R5 entry visible next search", result_addr, 8);
    chk("R8 hit clears miss", result_miss, 0);

    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      wr_valid  = ($urandom % 2) == 0;
      wr_word   = {2'($urandom), 12'd0, 2'($urandom)};
      del_valid = ($urandom % 4) == 0;
      del_addr  = 4'($urandom);
      sr_valid  = ($urandom % 5) < 3;
      sr_word   = {2'($urandom), 12'd0, 2'($urandom)};
    end
    @(negedge clk);
    wr_valid = 0; del_valid = 0; sr_valid = 0;
    repeat (3) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule